// File: doc/BRIEF.md
# Periodic Tick Deadline Rescheduler

This unit runs once for every timer interrupt. Software or a sequencer hands it the free-running counter value sampled at interrupt time, the deadline at which the tick was expected, and the tick period. The unit works out how many whole periods have passed since that deadline. It then produces the next expected deadline, kept on the period grid even when ticks were lost, and the value to write into a 32-bit compare register. It also raises a flag when delivery was so late that more than one second's worth of ticks went by.

Small delays resolve through a few cycles of repeated subtraction. Large delays go through a bit-serial divider. Both give the same results. When the next deadline falls too close to the present counter value, the compare value is pushed one extra period ahead so that the timer cannot miss it, while the stored deadline stays on the grid. An init command derives the period from a cycles-per-10 ms figure and arms the first deadline. A profiling sub-divider emits a pulse once every N tick invocations.

Top module: `tick_resched`

## Requirements
- R1: The elapsed count is `now_i - deadline_i` taken modulo 2^CNT_W, so a deadline just below the counter wrap and a counter just past it give a small elapsed count.
- R2: For a tick command, `ticks_o` = 1 + elapsed / period and the remainder is elapsed mod period. An exact multiple k·period gives k+1 ticks and remainder 0.
- R3: When elapsed >> 5 is below the period, the subtraction path is used: `done_o` comes 3 + floor(elapsed/period) cycles after start, which is 3 cycles for an elapsed count below one period. Otherwise a bit-serial divide is used, which takes at least CNT_W cycles. Both paths give identical outputs.
- R4: `deadline_o` = now + period − remainder, with CNT_W-bit wraparound.
- R5: Let gap = period − remainder. When gap >> 13 is zero (gap < 8192), `cmp_o` is the low 32 bits of `deadline_o` + period. Otherwise `cmp_o` is the low 32 bits of `deadline_o`. `deadline_o` itself is never advanced by this rule.
- R6: `late_o` is 1 exactly when `ticks_o` > TICK_HZ (default 100). 100 ticks gives 0 and 101 ticks gives 1.
- R7: An init command (`init_i`=1 with start) returns `period_o` = (100·`cyc10ms_i` mod 2^CNT_W) / TICK_HZ and `deadline_o` = now + that period. It also returns `cmp_o` = the low 32 bits of `deadline_o`, `ticks_o`=0, `late_o`=0 and `prof_o`=0. A tick command returns `period_o` = its `period_i`.
- R8: The profiling counter resets to 1 and is loaded with the multiplier by init. Each tick command decrements it. The tick that takes it to zero sets `prof_o`=1 and reloads it from that command's multiplier. A multiplier of 0 acts as 1.
- R9: `start_i` is ignored while a command is in progress. It neither changes that command's results nor produces an extra `done_o`.
- R10: `done_o` is a one-cycle pulse. All result outputs change only together with `done_o` and hold until the next completion.
- R11: After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, taken when idle |
| init_i | input | 1 | With start: 1 = init command, 0 = tick command |
| now_i | input | CNT_W | Counter value sampled at interrupt time |
| deadline_i | input | CNT_W | Expected deadline of this tick |
| period_i | input | CNT_W | Tick period in counter cycles (nonzero) |
| cyc10ms_i | input | CNT_W | Counter cycles per 10 ms (init only) |
| prof_mult_i | input | PROF_W | Profiling multiplier |
| done_o | output | 1 | One-cycle completion pulse |
| ticks_o | output | CNT_W | Ticks elapsed |
| deadline_o | output | CNT_W | Next expected deadline |
| cmp_o | output | CMP_W | Value for the compare register |
| late_o | output | 1 | More than TICK_HZ ticks elapsed |
| prof_o | output | 1 | Profiling pulse for this invocation |
| period_o | output | CNT_W | Period in use (derived on init) |

## Verification
A wrong remainder or tick count in the subtraction loop or the divider shows at the very next `done_o`. It appears as a deadline off the period grid or a tick count off by one, most visibly on exact multiples of the period where the two paths meet. A bad path choice shows first as a latency change of tens of cycles. A flipped skip decision appears as a `cmp_o` that differs from the low bits of `deadline_o` by exactly one period. A corrupted profiling count can stay hidden for up to a full multiplier's worth of invocations before the pulse lands on the wrong tick.

// File: rtl/tick_resched_pkg.sv
package tick_resched_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SUB  = 2'd1,
        ST_DIV  = 2'd2,
        ST_FIN  = 2'd3
    } rs_state_e;

endpackage

// File: rtl/tick_resched_div.sv
module tick_resched_div #(
    parameter int W = 40
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         done,
    output logic [W-1:0] quot,
    output logic [W-1:0] rem
);
    localparam int CNTW = $clog2(W + 1);
    localparam logic [CNTW-1:0] LAST = CNTW'(W - 1);

    typedef struct packed {
        logic            busy;
        logic [CNTW-1:0] cnt;
        logic [W-1:0]    q;
        logic [W-1:0]    r;
        logic [W-1:0]    d;
        logic            done;
    } div_t;

    div_t q_q, q_d;
    logic [W:0] shifted;
    logic [W:0] diff;

    always_comb begin
        q_d      = q_q;
        q_d.done = 1'b0;
        shifted  = {q_q.r, q_q.q[W-1]};
        diff     = shifted - {1'b0, q_q.d};
        if (go && !q_q.busy) begin
            q_d.busy = 1'b1;
            q_d.cnt  = '0;
            q_d.q    = dividend;
            q_d.r    = '0;
            q_d.d    = divisor;
        end else if (q_q.busy) begin
            if (shifted >= {1'b0, q_q.d}) begin
                q_d.r = diff[W-1:0];
                q_d.q = {q_q.q[W-2:0], 1'b1};
            end else begin
                q_d.r = shifted[W-1:0];
                q_d.q = {q_q.q[W-2:0], 1'b0};
            end
            q_d.cnt = q_q.cnt + CNTW'(1);
            if (q_q.cnt == LAST) begin
                q_d.busy = 1'b0;
                q_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    assign done = q_q.done;
    assign quot = q_q.q;
    assign rem  = q_q.r;

    // R2: a finished division always leaves a remainder below the divisor
    assert_div_rem_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (q_q.done && q_q.d != '0) |-> (q_q.r < q_q.d));

endmodule

// File: rtl/tick_resched_prof.sv
module tick_resched_prof #(
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    input  logic          load,
    input  logic [PW-1:0] mult,
    output logic          fire
);
    localparam logic [PW-1:0] ONE = PW'(1);

    typedef struct packed {
        logic [PW-1:0] cnt;
    } prof_t;

    prof_t q_q, q_d;
    logic [PW-1:0] reload;

    assign reload = (mult == '0) ? ONE : mult;
    assign fire   = step && (q_q.cnt <= ONE);

    always_comb begin
        q_d = q_q;
        if (load) begin
            q_d.cnt = reload;
        end else if (step) begin
            if (q_q.cnt <= ONE) q_d.cnt = reload;
            else                q_d.cnt = q_q.cnt - ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q.cnt <= ONE;
        else        q_q     <= q_d;
    end

    // R8: a firing step leaves the counter reloaded
    assert_prof_reload_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !load) |=> (q_q.cnt == $past(reload)));

    // R8: the counter never sits at zero
    assert_prof_nonzero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        q_q.cnt != '0);

endmodule

// File: rtl/tick_resched.sv
module tick_resched
    import tick_resched_pkg::*;
#(
    parameter int CNT_W      = 40,
    parameter int CMP_W      = 32,
    parameter int PROF_W     = 8,
    parameter int TICK_HZ    = 100,
    parameter int SCALE_10MS = 100,
    parameter int FAST_SHIFT = 5,
    parameter int SKIP_BITS  = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              init_i,
    input  logic [CNT_W-1:0]  now_i,
    input  logic [CNT_W-1:0]  deadline_i,
    input  logic [CNT_W-1:0]  period_i,
    input  logic [CNT_W-1:0]  cyc10ms_i,
    input  logic [PROF_W-1:0] prof_mult_i,
    output logic              done_o,
    output logic [CNT_W-1:0]  ticks_o,
    output logic [CNT_W-1:0]  deadline_o,
    output logic [CMP_W-1:0]  cmp_o,
    output logic              late_o,
    output logic              prof_o,
    output logic [CNT_W-1:0]  period_o
);
    localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);
    localparam logic [CNT_W-1:0] HZ_W    = CNT_W'(TICK_HZ);
    localparam logic [CNT_W-1:0] SCALE_W = CNT_W'(SCALE_10MS);
    localparam logic [CNT_W-1:0] FAST_MAX = CNT_W'(1 << FAST_SHIFT);

    typedef struct packed {
        rs_state_e          st;
        logic               init;
        logic [PROF_W-1:0]  mult;
        logic [CNT_W-1:0]   now;
        logic [CNT_W-1:0]   per;
        logic [CNT_W-1:0]   rem;
        logic [CNT_W-1:0]   tick;
        logic               done;
        logic [CNT_W-1:0]   ticks_o;
        logic [CNT_W-1:0]   next_o;
        logic [CMP_W-1:0]   cmp_o;
        logic               late_o;
        logic               prof_o;
        logic [CNT_W-1:0]   period_o;
    } rs_t;

    rs_t q_q, q_d;

    logic [CNT_W-1:0] elapsed;
    logic [CNT_W-1:0] gap;
    logic [CNT_W-1:0] nxt;
    logic [CNT_W-1:0] cmp_full;
    logic             skip;
    logic             div_go;
    logic [CNT_W-1:0] div_a;
    logic [CNT_W-1:0] div_b;
    logic             div_done;
    logic [CNT_W-1:0] div_q;
    logic [CNT_W-1:0] div_r;
    logic             prof_step;
    logic             prof_load;
    logic             prof_fire;

    tick_resched_div #(.W(CNT_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (div_go),
        .dividend (div_a),
        .divisor  (div_b),
        .done     (div_done),
        .quot     (div_q),
        .rem      (div_r)
    );

    assign prof_step = (q_q.st == ST_FIN) && !q_q.init;
    assign prof_load = (q_q.st == ST_FIN) &&  q_q.init;

    tick_resched_prof #(.PW(PROF_W)) u_prof (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (prof_step),
        .load  (prof_load),
        .mult  (q_q.mult),
        .fire  (prof_fire)
    );

    assign elapsed = now_i - deadline_i;

    always_comb begin
        q_d      = q_q;
        q_d.done = 1'b0;
        div_go   = 1'b0;
        div_a    = elapsed;
        div_b    = period_i;
        gap      = q_q.per - q_q.rem;
        nxt      = q_q.now + (q_q.init ? q_q.per : gap);
        skip     = !q_q.init && ((gap >> SKIP_BITS) == '0);
        cmp_full = skip ? (nxt + q_q.per) : nxt;

        case (q_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    q_d.init = init_i;
                    q_d.mult = prof_mult_i;
                    q_d.now  = now_i;
                    q_d.per  = period_i;
                    if (init_i) begin
                        div_go = 1'b1;
                        div_a  = cyc10ms_i * SCALE_W;
                        div_b  = HZ_W;
                        q_d.st = ST_DIV;
                    end else if ((elapsed >> FAST_SHIFT) < period_i) begin
                        q_d.rem  = elapsed;
                        q_d.tick = ONE;
                        q_d.st   = ST_SUB;
                    end else begin
                        div_go = 1'b1;
                        q_d.st = ST_DIV;
                    end
                end
            end
            ST_SUB: begin
                if (q_q.rem >= q_q.per) begin
                    q_d.rem  = q_q.rem - q_q.per;
                    q_d.tick = q_q.tick + ONE;
                end else begin
                    q_d.st = ST_FIN;
                end
            end
            ST_DIV: begin
                if (div_done) begin
                    if (q_q.init) begin
                        q_d.per  = div_q;
                        q_d.tick = '0;
                    end else begin
                        q_d.rem  = div_r;
                        q_d.tick = div_q + ONE;
                    end
                    q_d.st = ST_FIN;
                end
            end
            default: begin
                q_d.ticks_o  = q_q.tick;
                q_d.next_o   = nxt;
                q_d.cmp_o    = cmp_full[CMP_W-1:0];
                q_d.late_o   = !q_q.init && (q_q.tick > HZ_W);
                q_d.prof_o   = prof_fire;
                q_d.period_o = q_q.per;
                q_d.done     = 1'b1;
                q_d.st       = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    assign done_o     = q_q.done;
    assign ticks_o    = q_q.ticks_o;
    assign deadline_o = q_q.next_o;
    assign cmp_o      = q_q.cmp_o;
    assign late_o     = q_q.late_o;
    assign prof_o     = q_q.prof_o;
    assign period_o   = q_q.period_o;

    // R3: the subtraction loop stays within its bounded iteration count
    assert_fast_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (q_q.st == ST_SUB) |-> (q_q.tick <= FAST_MAX));

    // R4: a tick result lands within one period after the sampled counter
    assert_gap_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !q_q.init && q_q.per != '0) |->
        ((deadline_o - q_q.now) != '0 && (deadline_o - q_q.now) <= q_q.per));

    // R5: the compare value is the deadline or exactly one period past it
    assert_cmp_offset_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !q_q.init) |->
        (cmp_o == deadline_o[CMP_W-1:0] ||
         cmp_o == CMP_W'(deadline_o + period_o)));

    // R6: the late flag follows the reported tick count
    assert_late_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (late_o == (ticks_o > HZ_W)));

    // R9: a start during a running command leaves the latched operands alone
    assert_busy_ignore_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && q_q.st != ST_IDLE) |=> $stable(q_q.now));

    // R10: done is a single-cycle pulse
    assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R10: results move only together with done
    assert_outputs_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(ticks_o) && $stable(deadline_o) && $stable(cmp_o) &&
                     $stable(late_o) && $stable(prof_o) && $stable(period_o)));

endmodule

// File: tb/tick_resched_bench.sv
module tick_resched_bench;
    localparam int W  = 40;
    localparam int CW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          init_i = 1'b0;
    logic [W-1:0]  now_i = '0;
    logic [W-1:0]  deadline_i = '0;
    logic [W-1:0]  period_i = '0;
    logic [W-1:0]  cyc10ms_i = '0;
    logic [7:0]    prof_mult_i = '0;
    logic          done_o;
    logic [W-1:0]  ticks_o;
    logic [W-1:0]  deadline_o;
    logic [CW-1:0] cmp_o;
    logic          late_o;
    logic          prof_o;
    logic [W-1:0]  period_o;

    tick_resched u_tick_resched (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .init_i(init_i),
        .now_i(now_i), .deadline_i(deadline_i), .period_i(period_i),
        .cyc10ms_i(cyc10ms_i), .prof_mult_i(prof_mult_i), .done_o(done_o),
        .ticks_o(ticks_o), .deadline_o(deadline_o), .cmp_o(cmp_o),
        .late_o(late_o), .prof_o(prof_o), .period_o(period_o)
    );

    always #4 clk = ~clk;

    int total = 0;
    int bad = 0;
    int wd = 0;
    int lat;

    logic [W-1:0]  m_ticks, m_next, m_period;
    logic [CW-1:0] m_cmp;
    logic          m_late, m_prof;
    logic [7:0]    m_cnt = 8'd1;

    always @(posedge clk) begin
        wd <= wd + 1;
        if (wd > 150000) begin
            bad = bad + 1;
            total = total + 1;
            $display("FAIL watchdog act=%0d exp=<150000", wd);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic model_tick(input logic [W-1:0] now, input logic [W-1:0] dl,
                              input logic [W-1:0] per, input logic [7:0] mult);
        logic [W-1:0] e, rem, gap, full;
        e       = now - dl;
        m_ticks = 1 + e / per;
        rem     = e % per;
        gap     = per - rem;
        m_next  = now + gap;
        full    = (gap < 8192) ? m_next + per : m_next;
        m_cmp   = full[CW-1:0];
        m_late  = m_ticks > 100;
        m_period = per;
        if (m_cnt <= 1) begin
            m_prof = 1'b1;
            m_cnt  = (mult == 0) ? 8'd1 : mult;
        end else begin
            m_prof = 1'b0;
            m_cnt  = m_cnt - 1;
        end
    endtask

    task automatic issue(input logic ini, input logic [W-1:0] now, input logic [W-1:0] dl,
                         input logic [W-1:0] per, input logic [W-1:0] c10, input logic [7:0] mult);
        @(negedge clk);
        start_i = 1'b1; init_i = ini; now_i = now; deadline_i = dl;
        period_i = per; cyc10ms_i = c10; prof_mult_i = mult;
        @(negedge clk);
        start_i = 1'b0;
        lat = 1;
    endtask

    task automatic wait_done;
        while (!done_o) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic run_tick(input logic [W-1:0] now, input logic [W-1:0] dl,
                            input logic [W-1:0] per, input logic [7:0] mult);
        model_tick(now, dl, per, mult);
        issue(1'b0, now, dl, per, '0, mult);
        wait_done();
    endtask

    task automatic check_all(input string sc);
        chk({sc, " R2 ticks"}, 64'(ticks_o), 64'(m_ticks));
        chk({sc, " R4 deadline"}, 64'(deadline_o), 64'(m_next));
        chk({sc, " R5 cmp"}, 64'(cmp_o), 64'(m_cmp));
        chk({sc, " R6 late"}, 64'(late_o), 64'(m_late));
        chk({sc, " R8 prof"}, 64'(prof_o), 64'(m_prof));
        chk({sc, " R7 period"}, 64'(period_o), 64'(m_period));
    endtask

    task automatic t_reset;
        chk("R11 done", 64'(done_o), 0);
        chk("R11 ticks", 64'(ticks_o), 0);
        chk("R11 deadline", 64'(deadline_o), 0);
        chk("R11 cmp", 64'(cmp_o), 0);
        chk("R11 flags", 64'({late_o, prof_o}), 0);
        chk("R11 period", 64'(period_o), 0);
    endtask

    task automatic t_init(input logic [W-1:0] now, input logic [W-1:0] c10, input logic [7:0] mult);
        logic [W-1:0] p;
        p = (c10 * 100) / 100;
        issue(1'b1, now, '0, '0, c10, mult);
        wait_done();
        m_cnt = (mult == 0) ? 8'd1 : mult;
        chk("R7 init period", 64'(period_o), 64'(p));
        chk("R7 init deadline", 64'(deadline_o), 64'(now + p));
        chk("R7 init cmp", 64'(cmp_o), 64'((now + p) & 40'hFF_FFFF_FFFF) & 64'hFFFF_FFFF);
        chk("R7 init ticks", 64'(ticks_o), 0);
        chk("R7 init flags", 64'({late_o, prof_o}), 0);
    endtask

    task automatic t_ontime;
        run_tick(40'd2_000_300, 40'd2_000_000, 40'd1_000_000, 8'd0);
        check_all("ontime");
        chk("R3 fast latency", 64'(lat), 3);
    endtask

    task automatic t_exact_fast;
        run_tick(40'd3_500_000, 40'd500_000, 40'd1_000_000, 8'd0);
        check_all("exact-fast R2");
        chk("R3 fast latency multiple", 64'(lat), 6);
    endtask

    task automatic t_missed_slow;
        run_tick(40'd100_000 + 40'd50_123, 40'd100_000, 40'd1000, 8'd0);
        check_all("missed-slow");
        chk("R3 slow path latency", 64'(lat >= W), 1);
    endtask

    task automatic t_exact_slow;
        run_tick(40'd900_000 + 40'd200_000, 40'd900_000, 40'd1000, 8'd0);
        check_all("exact-slow R2 R3");
    endtask

    task automatic t_late_boundary;
        run_tick(40'd10_000 + 40'd99_005, 40'd10_000, 40'd1000, 8'd0);
        check_all("late100");
        chk("R6 exactly 100 not late", 64'(late_o), 0);
        run_tick(40'd10_000 + 40'd100_000, 40'd10_000, 40'd1000, 8'd0);
        check_all("late101");
        chk("R6 101 is late", 64'(late_o), 1);
    endtask

    task automatic t_skip_boundary;
        run_tick(40'd50_000 + 40'd1808, 40'd50_000, 40'd10_000, 8'd0);
        check_all("gap8192");
        chk("R5 no skip at 8192", 64'(cmp_o), 64'(m_next[CW-1:0]));
        run_tick(40'd50_000 + 40'd1809, 40'd50_000, 40'd10_000, 8'd0);
        check_all("gap8191");
        chk("R5 skip at 8191", 64'(cmp_o), 64'(m_next[CW-1:0] + 32'd10_000));
        chk("R5 deadline not advanced", 64'(deadline_o), 64'(40'd50_000 + 40'd10_000));
    endtask

    task automatic t_wrap;
        run_tick(40'h00_0000_0040, 40'hFF_FFFF_FF00, 40'd1000, 8'd0);
        check_all("wrap");
        chk("R1 wrapped elapsed ticks", 64'(ticks_o), 1);
        chk("R1 wrapped deadline", 64'(deadline_o), 64'(40'h40 + 40'd680));
    endtask

    task automatic t_truncate;
        run_tick(40'h5A_0000_1000, 40'h5A_0000_1000 - 40'd500, 40'd1_000_000, 8'd0);
        check_all("trunc");
        chk("R5 low 32 bits only", 64'(cmp_o), 64'(deadline_o[CW-1:0]));
    endtask

    task automatic t_busy_ignore;
        int extra;
        model_tick(40'd100_000 + 40'd50_123, 40'd100_000, 40'd1000, 8'd0);
        issue(1'b0, 40'd100_000 + 40'd50_123, 40'd100_000, 40'd1000, '0, 8'd0);
        repeat (3) begin @(negedge clk); lat++; end
        start_i = 1'b1; init_i = 1'b1; now_i = 40'd7; cyc10ms_i = 40'd5000; period_i = 40'd3;
        @(negedge clk);
        start_i = 1'b0; lat++;
        wait_done();
        check_all("busy R9");
        extra = 0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (done_o) extra++;
        end
        chk("R9 no extra done", 64'(extra), 0);
    endtask

    task automatic t_hold;
        logic [W-1:0] t, d;
        logic [CW-1:0] c;
        run_tick(40'd800_000, 40'd700_000, 40'd30_000, 8'd0);
        check_all("hold");
        t = ticks_o; d = deadline_o; c = cmp_o;
        @(negedge clk);
        chk("R10 done single cycle", 64'(done_o), 0);
        repeat (8) @(negedge clk);
        chk("R10 ticks held", 64'(ticks_o), 64'(t));
        chk("R10 deadline held", 64'(deadline_o), 64'(d));
        chk("R10 cmp held", 64'(cmp_o), 64'(c));
    endtask

    task automatic t_prof;
        t_init(40'd1000, 40'd20_000, 8'd3);
        for (int i = 1; i <= 6; i++) begin
            run_tick(40'd5000, 40'd4900, 40'd20_000, 8'd3);
            check_all("prof3");
            chk("R8 pulse every third", 64'(prof_o), 64'(i % 3 == 0));
        end
        t_init(40'd1000, 40'd20_000, 8'd0);
        for (int i = 0; i < 2; i++) begin
            run_tick(40'd5000, 40'd4900, 40'd20_000, 8'd0);
            chk("R8 mult zero fires every tick", 64'(prof_o), 1);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_init(40'd5000, 40'd1_000_000, 8'd4);
        t_ontime();
        t_exact_fast();
        t_missed_slow();
        t_exact_slow();
        t_late_boundary();
        t_skip_boundary();
        t_wrap();
        t_truncate();
        t_busy_ignore();
        t_hold();
        t_prof();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule